// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an already decoded memory-operand descriptor into a linear effective address of the form base + index × scale + displacement. The descriptor carries a two-bit mode field, a four-bit register/memory selector, the scale/index/base fields of the optional scale-index byte, a raw 32-bit displacement, and a few flags. The unit drives a two-address read port into a 16-entry register file kept outside the block and takes the data back combinationally in the same cycle.

Three address sizes are handled. In 16-bit size, fixed register pairs are chosen by the selector and the sum wraps at 16 bits. In 32-bit and 64-bit size, the unit uses the scale-index byte form, a pointer-relative form that is taken from the end of the current instruction, and a compressed 8-bit displacement that is multiplied by a power-of-two operand size. The result is cut to the active address size, zero-extended to 64 bits, and leaves the unit two clock edges after the descriptor is accepted. One descriptor can be accepted every cycle.

Top module: `ea_gen`

## Requirements
- R1: When the scale-index byte is in use, `in_scale` codes 2'b00, 2'b01, 2'b10 and 2'b11 multiply the index register by 1, 2, 4 and 8.
- R2: With `in_asz` = 2'b10 (64-bit), all 64 register bits take part in the sum, and the displacement (8 bits for `in_mod` 2'b01, 32 bits for 2'b10) is sign-extended to 64 bits before the add.
- R3: With `in_asz` = 2'b00 (16-bit), `in_rm[2:0]` picks registers 0→3+6, 1→3+7, 2→5+6, 3→5+7, 4→6, 5→7, 6→5, 7→3, with no scaling; `in_mod` 2'b01 adds a sign-extended disp8, 2'b10 a disp16; `in_mod` 2'b00 with `in_rm[2:0]` = 3'b110 gives disp16 alone; the sum wraps modulo 2^16 and bits 63:16 are zero.
- R4: With `in_mod` 2'b00 and `in_rm[2:0]` = 3'b101 in 32/64-bit size, `in_long` = 1 gives `in_ip` + `in_ilen` + sign-extended disp32, cut to 32 bits when `in_asz` = 2'b01; `in_long` = 0 gives the disp32 alone as an absolute address.
- R5: When `in_cdisp` is set and `in_mod` is 2'b01, the sign-extended disp8 is shifted left by `in_nlog` (N = 2^`in_nlog`, 0 to 6) before the add.
- R6: A disp16 or disp32 is never multiplied, whatever `in_cdisp` and `in_nlog` hold.
- R7: An `in_index` value of 4'b0100 means no index unless `in_vidx` is set, in which case register 4 is used as the index; 4'b1100 always indexes register 12.
- R8: `in_rm[2:0]` = 3'b100 selects the scale-index byte and the pointer-relative test uses only `in_rm[2:0]`, regardless of `in_rm[3]`; inside the scale-index byte, `in_mod` 2'b00 with `in_base[2:0]` = 3'b101 drops the base and adds a disp32.
- R9: With `in_asz` = 2'b01 (32-bit), the sum is cut to 32 bits and bits 63:32 of `out_addr` are zero.
- R10: A descriptor accepted at a rising edge with `in_mod` other than 2'b11 yields `out_valid` = 1 and its address after the second rising edge; one descriptor is accepted per cycle, and `in_mod` = 2'b11 (register operand) yields no valid output.
- R11: While `rst_n` is low, `out_valid` is 0, and a descriptor caught in the pipeline by reset never emerges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor present this cycle |
| in_asz | input | 2 | Address size: 00 = 16, 01 = 32, 10 = 64 bit |
| in_long | input | 1 | Long-mode execution (enables pointer-relative form) |
| in_mod | input | 2 | Addressing mode field |
| in_rm | input | 4 | Register/memory selector with extension bit in bit 3 |
| in_scale | input | 2 | Scale code of the scale-index byte |
| in_index | input | 4 | Index register code with extension bit |
| in_base | input | 4 | Base register code with extension bit |
| in_disp | input | 32 | Raw displacement, low bytes used per mode |
| in_vidx | input | 1 | Vector-index flag: index code 4 is a real index |
| in_cdisp | input | 1 | Compressed 8-bit displacement flag |
| in_nlog | input | 3 | log2 of the compressed displacement multiplier |
| in_ip | input | 64 | Current instruction pointer |
| in_ilen | input | 4 | Length of the current instruction in bytes |
| rf_ra0 | output | 4 | Register file read address, base |
| rf_rd0 | input | 64 | Register file read data, base |
| rf_ra1 | output | 4 | Register file read address, index |
| rf_rd1 | input | 64 | Register file read data, index |
| out_valid | output | 1 | Effective address valid |
| out_addr | output | 64 | Effective address, zero-extended |

## Verification
The bench chases the encodings that redirect the sum: the "no index" code with and without the vector flag and with its extension bit set, the base-less scale-index form, and the pointer-relative form with the selector's extension bit set, where a decoder that looked at all four bits would fetch register 13 instead of the instruction pointer. It loads register values whose low 16 bits sum past 2^16 and whose 32-bit sums carry out, so a design that forgets to cut the result leaks high bits. Compressed scaling is checked on a negative disp8 and against wider displacements with the flag still set, where a wrongly scaled disp32 would jump by a multiple of 64. Back-to-back descriptors with a register-operand one in between expose a pipeline that drops, duplicates or mis-times results.

// File: rtl/ea_gen_pkg.sv
`timescale 1ns/1ps
package ea_gen_pkg;

   typedef enum logic [1:0] {
      ASZ16 = 2'b00,
      ASZ32 = 2'b01,
      ASZ64 = 2'b10,
      ASZRS = 2'b11
   } asz_e;

   typedef enum logic [1:0] {
      DK_NONE = 2'b00,
      DK_D8   = 2'b01,
      DK_D16  = 2'b10,
      DK_D32  = 2'b11
   } dkind_e;

   typedef struct packed {
      logic       use_base;
      logic       use_idx;
      logic       use_ip;
      logic [1:0] scale;
      dkind_e     dk;
   } sel_t;

endpackage

// File: rtl/ea_gen_dec.sv
`timescale 1ns/1ps
module ea_gen_dec
   import ea_gen_pkg::*;
#(
   parameter int RIDX_W = 4
)
(
   input  asz_e              asz,
   input  logic              lng,
   input  logic [1:0]        md,
   input  logic [RIDX_W-1:0] rm,
   input  logic [RIDX_W-1:0] sib_base,
   input  logic [RIDX_W-1:0] sib_index,
   input  logic [1:0]        sib_scale,
   input  logic              vidx,
   output sel_t              sel,
   output logic              mem,
   output logic [RIDX_W-1:0] ra_b,
   output logic [RIDX_W-1:0] ra_i
);

   localparam logic [RIDX_W-1:0] R3     = RIDX_W'(3);
   localparam logic [RIDX_W-1:0] R5     = RIDX_W'(5);
   localparam logic [RIDX_W-1:0] R6     = RIDX_W'(6);
   localparam logic [RIDX_W-1:0] R7     = RIDX_W'(7);
   localparam logic [RIDX_W-1:0] NO_IDX = RIDX_W'(4);

   always_comb begin
      sel  = '0;
      ra_b = '0;
      ra_i = '0;
      mem  = (md != 2'b11);
      case (md)
         2'b01:   sel.dk = DK_D8;
         2'b10:   sel.dk = (asz == ASZ16) ? DK_D16 : DK_D32;
         default: sel.dk = DK_NONE;
      endcase
      if (asz == ASZ16) begin
         // fixed pairs, scale stays zero
         case (rm[2:0])
            3'd0: begin sel.use_base = 1'b1; ra_b = R3; sel.use_idx = 1'b1; ra_i = R6; end
            3'd1: begin sel.use_base = 1'b1; ra_b = R3; sel.use_idx = 1'b1; ra_i = R7; end
            3'd2: begin sel.use_base = 1'b1; ra_b = R5; sel.use_idx = 1'b1; ra_i = R6; end
            3'd3: begin sel.use_base = 1'b1; ra_b = R5; sel.use_idx = 1'b1; ra_i = R7; end
            3'd4: begin sel.use_base = 1'b1; ra_b = R6; end
            3'd5: begin sel.use_base = 1'b1; ra_b = R7; end
            3'd6: begin
               if (md == 2'b00) sel.dk = DK_D16;
               else begin sel.use_base = 1'b1; ra_b = R5; end
            end
            default: begin sel.use_base = 1'b1; ra_b = R3; end
         endcase
      end else if (rm[2:0] == 3'b100) begin
         sel.scale   = sib_scale;
         ra_i        = sib_index;
         sel.use_idx = vidx || (sib_index != NO_IDX);
         if (md == 2'b00 && sib_base[2:0] == 3'b101) begin
            sel.dk = DK_D32;
         end else begin
            sel.use_base = 1'b1;
            ra_b         = sib_base;
         end
      end else if (md == 2'b00 && rm[2:0] == 3'b101) begin
         sel.dk     = DK_D32;
         sel.use_ip = lng;
      end else begin
         sel.use_base = 1'b1;
         ra_b         = rm;
      end
   end

endmodule

// File: rtl/ea_gen_opnd.sv
`timescale 1ns/1ps
module ea_gen_opnd
   import ea_gen_pkg::*;
#(
   parameter int AW       = 64,
   parameter int DW       = 32,
   parameter int NLW      = 3,
   parameter int ILW      = 4,
   parameter bit CDISP_EN = 1'b1
)
(
   input  sel_t           sel,
   input  logic [AW-1:0]  rd_b,
   input  logic [AW-1:0]  rd_i,
   input  logic [DW-1:0]  disp,
   input  logic           cdisp,
   input  logic [NLW-1:0] nlog,
   input  logic [AW-1:0]  ip,
   input  logic [ILW-1:0] ilen,
   output logic [AW-1:0]  base_v,
   output logic [AW-1:0]  idx_v,
   output logic [AW-1:0]  disp_v
);

   logic [AW-1:0] d8, d8s, d16, d32, next_ip;

   assign d8      = {{(AW-8){disp[7]}}, disp[7:0]};
   assign d16     = {{(AW-16){disp[15]}}, disp[15:0]};
   assign d32     = {{(AW-DW){disp[DW-1]}}, disp};
   assign next_ip = ip + {{(AW-ILW){1'b0}}, ilen};

   generate
      if (CDISP_EN) begin : g_cdisp
         assign d8s = cdisp ? (d8 << nlog) : d8;
      end else begin : g_plain
         assign d8s = d8;
      end
   endgenerate

   always_comb begin
      if (sel.use_ip)        base_v = next_ip;
      else if (sel.use_base) base_v = rd_b;
      else                   base_v = '0;
      idx_v = sel.use_idx ? (rd_i << sel.scale) : '0;
      case (sel.dk)
         DK_D8:   disp_v = d8s;
         DK_D16:  disp_v = d16;
         DK_D32:  disp_v = d32;
         default: disp_v = '0;
      endcase
   end

endmodule

// File: rtl/ea_gen_add.sv
`timescale 1ns/1ps
module ea_gen_add
   import ea_gen_pkg::*;
#(
   parameter int AW = 64
)
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          v_in,
   input  asz_e          asz,
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] b,
   input  logic [AW-1:0] c,
   output logic          v_out,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] sum, cut;

   always_comb begin
      sum = a + b + c;
      case (asz)
         ASZ16:   cut = {{(AW-16){1'b0}}, sum[15:0]};
         ASZ32:   cut = {{(AW-32){1'b0}}, sum[31:0]};
         default: cut = sum;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_out <= 1'b0;
      else        v_out <= v_in;
   end

   always_ff @(posedge clk) begin
      if (v_in) addr <= cut;
   end

endmodule

// File: rtl/ea_gen.sv
`timescale 1ns/1ps
module ea_gen
   import ea_gen_pkg::*;
#(
   parameter int AW       = 64,
   parameter int DW       = 32,
   parameter int RF_DEPTH = 16,
   parameter int NLW      = 3,
   parameter int ILW      = 4,
   parameter bit CDISP_EN = 1'b1
)
(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [1:0]                  in_asz,
   input  logic                        in_long,
   input  logic [1:0]                  in_mod,
   input  logic [$clog2(RF_DEPTH)-1:0] in_rm,
   input  logic [1:0]                  in_scale,
   input  logic [$clog2(RF_DEPTH)-1:0] in_index,
   input  logic [$clog2(RF_DEPTH)-1:0] in_base,
   input  logic [DW-1:0]               in_disp,
   input  logic                        in_vidx,
   input  logic                        in_cdisp,
   input  logic [NLW-1:0]              in_nlog,
   input  logic [AW-1:0]               in_ip,
   input  logic [ILW-1:0]              in_ilen,
   output logic [$clog2(RF_DEPTH)-1:0] rf_ra0,
   input  logic [AW-1:0]               rf_rd0,
   output logic [$clog2(RF_DEPTH)-1:0] rf_ra1,
   input  logic [AW-1:0]               rf_rd1,
   output logic                        out_valid,
   output logic [AW-1:0]               out_addr
);

   localparam int RIDX_W = $clog2(RF_DEPTH);

   generate
      if (RIDX_W != 4) begin : g_bad_rf
         $error("ea_gen: register file must have 16 entries");
      end
      if (AW < 32 || AW <= DW) begin : g_bad_aw
         $error("ea_gen: address width must exceed displacement width and be >= 32");
      end
      if (DW < 16) begin : g_bad_dw
         $error("ea_gen: displacement width must be >= 16");
      end
   endgenerate

   sel_t          sel;
   logic          mem;
   asz_e          asz_in;
   logic [AW-1:0] base_v, idx_v, disp_v;

   assign asz_in = asz_e'(in_asz);

   ea_gen_dec #(.RIDX_W(RIDX_W)) u_dec (
      .asz       (asz_in),
      .lng       (in_long),
      .md        (in_mod),
      .rm        (in_rm),
      .sib_base  (in_base),
      .sib_index (in_index),
      .sib_scale (in_scale),
      .vidx      (in_vidx),
      .sel       (sel),
      .mem       (mem),
      .ra_b      (rf_ra0),
      .ra_i      (rf_ra1)
   );

   ea_gen_opnd #(
      .AW(AW), .DW(DW), .NLW(NLW), .ILW(ILW), .CDISP_EN(CDISP_EN)
   ) u_opnd (
      .sel    (sel),
      .rd_b   (rf_rd0),
      .rd_i   (rf_rd1),
      .disp   (in_disp),
      .cdisp  (in_cdisp),
      .nlog   (in_nlog),
      .ip     (in_ip),
      .ilen   (in_ilen),
      .base_v (base_v),
      .idx_v  (idx_v),
      .disp_v (disp_v)
   );

   // stage 1: operands registered
   logic          v1;
   asz_e          asz1;
   logic [AW-1:0] base1, idx1, disp1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v1 <= 1'b0;
      else        v1 <= in_valid && mem;
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         asz1  <= asz_in;
         base1 <= base_v;
         idx1  <= idx_v;
         disp1 <= disp_v;
      end
   end

   // stage 2: sum and size cut
   ea_gen_add #(.AW(AW)) u_add (
      .clk   (clk),
      .rst_n (rst_n),
      .v_in  (v1),
      .asz   (asz1),
      .a     (base1),
      .b     (idx1),
      .c     (disp1),
      .v_out (out_valid),
      .addr  (out_addr)
   );

endmodule

// File: rtl/ea_gen_chk.sv
`timescale 1ns/1ps
module ea_gen_chk #(
   parameter int AW = 64
)
(
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [1:0]    in_asz,
   input logic [1:0]    in_mod,
   input logic [3:0]    rf_ra0,
   input logic [3:0]    rf_ra1,
   input logic          out_valid,
   input logic [AW-1:0] out_addr
);

   logic       t1_v, t2_v;
   logic [1:0] t1_a, t2_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t1_v <= 1'b0;
         t2_v <= 1'b0;
         t1_a <= 2'b00;
         t2_a <= 2'b00;
      end else begin
         t1_v <= in_valid && (in_mod != 2'b11);
         t2_v <= t1_v;
         t1_a <= in_asz;
         t2_a <= t1_a;
      end
   end

   // R10: valid appears exactly two edges after a memory descriptor
   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == t2_v);

   // R3: 16-bit results carry nothing above bit 15
   p_wrap16_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && t2_a == 2'b00) |-> (out_addr[AW-1:16] == '0));

   // R3: 16-bit size reads only registers 0..7
   p_rf16_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_asz == 2'b00) |-> (!rf_ra0[3] && !rf_ra1[3]));

   // R9: 32-bit results are zero-extended
   p_cut32_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && t2_a == 2'b01) |-> (out_addr[AW-1:32] == '0));

   // R11: reset keeps the output idle
   p_reset_r11: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_asz    (in_asz),
   .in_mod    (in_mod),
   .rf_ra0    (rf_ra0),
   .rf_ra1    (rf_ra1),
   .out_valid (out_valid),
   .out_addr  (out_addr)
);

// File: tb/ea_gen_bench.sv
`timescale 1ns/1ps
module ea_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid, in_long, in_vidx, in_cdisp;
   logic [1:0]  in_asz, in_mod, in_scale;
   logic [3:0]  in_rm, in_index, in_base, in_ilen;
   logic [31:0] in_disp;
   logic [2:0]  in_nlog;
   logic [63:0] in_ip;
   logic [3:0]  rf_ra0, rf_ra1;
   logic [63:0] rf_rd0, rf_rd1;
   logic        out_valid;
   logic [63:0] out_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [63:0] rfv(input logic [3:0] i);
      logic [63:0] e;
      e = {60'd0, i};
      return 64'h8000_0000_0000_F000 + (e << 32) + (e << 16) + e;
   endfunction

   function automatic logic [63:0] lo16(input logic [63:0] x);
      return {48'd0, x[15:0]};
   endfunction

   function automatic logic [63:0] lo32(input logic [63:0] x);
      return {32'd0, x[31:0]};
   endfunction

   always_comb begin
      rf_rd0 = rfv(rf_ra0);
      rf_rd1 = rfv(rf_ra1);
   end

   ea_gen u_ea_gen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_asz(in_asz),
      .in_long(in_long), .in_mod(in_mod), .in_rm(in_rm), .in_scale(in_scale),
      .in_index(in_index), .in_base(in_base), .in_disp(in_disp),
      .in_vidx(in_vidx), .in_cdisp(in_cdisp), .in_nlog(in_nlog),
      .in_ip(in_ip), .in_ilen(in_ilen),
      .rf_ra0(rf_ra0), .rf_rd0(rf_rd0), .rf_ra1(rf_ra1), .rf_rd1(rf_rd1),
      .out_valid(out_valid), .out_addr(out_addr)
   );

   task automatic expect_addr(input string req, input logic [63:0] exp);
      checks++;
      if (out_valid !== 1'b1 || out_addr !== exp) begin
         errors++;
         $display("FAIL %s: valid=%0b addr=%h expected valid=1 addr=%h",
                  req, out_valid, out_addr, exp);
      end
   endtask

   task automatic expect_idle(input string req);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL %s: valid=%0b expected valid=0", req, out_valid);
      end
   endtask

   task automatic dflt();
      in_valid = 1'b0; in_asz = 2'b10; in_long = 1'b1; in_mod = 2'b00;
      in_rm = 4'd0; in_scale = 2'b00; in_index = 4'd0; in_base = 4'd0;
      in_disp = 32'd0; in_vidx = 1'b0; in_cdisp = 1'b0; in_nlog = 3'd0;
      in_ip = 64'd0; in_ilen = 4'd0;
   endtask

   task automatic fire(input string req, input logic [63:0] exp);
      @(negedge clk); in_valid = 1'b1;
      @(negedge clk); in_valid = 1'b0;
      expect_idle({req, " one edge"});
      @(negedge clk); expect_addr(req, exp);
   endtask

   task automatic t_reset();
      expect_idle("R11 during reset");
      @(negedge clk); rst_n = 1'b1;
      dflt(); in_rm = 4'd1; in_mod = 2'b10;
      @(negedge clk); in_valid = 1'b1;
      @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
      expect_idle("R11 reset asserted");
      @(negedge clk); rst_n = 1'b1;
      expect_idle("R11 flushed");
      @(negedge clk); expect_idle("R11 nothing emerges");
   endtask

   task automatic t_scale();
      for (int s = 0; s < 4; s++) begin
         dflt(); in_rm = 4'b0100; in_base = 4'd1; in_index = 4'd2; in_scale = 2'(s);
         fire("R1 scale", rfv(4'd1) + (rfv(4'd2) << s));
      end
   endtask

   task automatic t_disp64();
      dflt(); in_rm = 4'd1; in_mod = 2'b10; in_disp = 32'hFFFF_FF00;
      fire("R2 disp32 negative", rfv(4'd1) - 64'h100);
      dflt(); in_rm = 4'd9; in_mod = 2'b01; in_disp = 32'h0000_0080;
      fire("R2 disp8 negative ext reg", rfv(4'd9) - 64'h80);
   endtask

   task automatic t_a16();
      for (int r = 0; r < 8; r++) begin
         logic [63:0] e;
         case (r)
            0: e = rfv(4'd3) + rfv(4'd6);
            1: e = rfv(4'd3) + rfv(4'd7);
            2: e = rfv(4'd5) + rfv(4'd6);
            3: e = rfv(4'd5) + rfv(4'd7);
            4: e = rfv(4'd6);
            5: e = rfv(4'd7);
            6: e = rfv(4'd5);
            default: e = rfv(4'd3);
         endcase
         dflt(); in_asz = 2'b00; in_long = 1'b0; in_mod = 2'b01;
         in_rm = 4'(r); in_disp = 32'h10; in_scale = 2'b11;
         fire("R3 pair", lo16(e + 64'h10));
      end
      dflt(); in_asz = 2'b00; in_mod = 2'b00; in_rm = 4'd6; in_disp = 32'h0000_1234;
      fire("R3 disp16 alone", 64'h1234);
      dflt(); in_asz = 2'b00; in_mod = 2'b10; in_rm = 4'd0; in_disp = 32'h0000_FFFF;
      fire("R3 disp16 wrap", lo16(rfv(4'd3) + rfv(4'd6) - 64'd1));
   endtask

   task automatic t_iprel();
      dflt(); in_rm = 4'd5; in_ip = 64'h0000_1234_5678_9000; in_ilen = 4'd7;
      in_disp = 32'hFFFF_FFF0;
      fire("R4 pointer relative 64", 64'h0000_1234_5678_9000 + 64'd7 - 64'd16);
      dflt(); in_asz = 2'b01; in_rm = 4'd5; in_ip = 64'hFFFF_FFFF_FFFF_FFF8;
      in_ilen = 4'd10; in_disp = 32'h20;
      fire("R4 pointer relative 32", 64'h22);
      dflt(); in_asz = 2'b01; in_long = 1'b0; in_rm = 4'd5; in_disp = 32'h0040_0000;
      fire("R4 absolute", 64'h0040_0000);
      dflt(); in_rm = 4'd13; in_ip = 64'h1000; in_ilen = 4'd3; in_disp = 32'h4;
      fire("R8 ext bit ignored for pointer form", 64'h1007);
   endtask

   task automatic t_cdisp();
      dflt(); in_rm = 4'd1; in_mod = 2'b01; in_disp = 32'h01; in_cdisp = 1'b1; in_nlog = 3'd6;
      fire("R5 disp8 x64", rfv(4'd1) + 64'h40);
      dflt(); in_rm = 4'd1; in_mod = 2'b01; in_disp = 32'hFF; in_cdisp = 1'b1; in_nlog = 3'd3;
      fire("R5 negative disp8 x8", rfv(4'd1) - 64'd8);
   endtask

   task automatic t_noscale();
      dflt(); in_rm = 4'd1; in_mod = 2'b10; in_disp = 32'h10; in_cdisp = 1'b1; in_nlog = 3'd6;
      fire("R6 disp32 unscaled", rfv(4'd1) + 64'h10);
      dflt(); in_asz = 2'b00; in_mod = 2'b10; in_rm = 4'd0; in_disp = 32'h10;
      in_cdisp = 1'b1; in_nlog = 3'd6;
      fire("R6 disp16 unscaled", lo16(rfv(4'd3) + rfv(4'd6) + 64'h10));
   endtask

   task automatic t_index();
      dflt(); in_rm = 4'b0100; in_base = 4'd1; in_index = 4'b0100; in_mod = 2'b01; in_disp = 32'h8;
      fire("R7 no index", rfv(4'd1) + 64'h8);
      dflt(); in_rm = 4'b0100; in_base = 4'd1; in_index = 4'b0100; in_vidx = 1'b1; in_scale = 2'b01;
      fire("R7 vector index 4", rfv(4'd1) + (rfv(4'd4) << 1));
      dflt(); in_rm = 4'b0100; in_base = 4'd1; in_index = 4'b1100;
      fire("R7 index 12", rfv(4'd1) + rfv(4'd12));
   endtask

   task automatic t_nobase();
      dflt(); in_rm = 4'b0100; in_base = 4'b0101; in_index = 4'd2; in_scale = 2'b10; in_disp = 32'h1000;
      fire("R8 no base", (rfv(4'd2) << 2) + 64'h1000);
      dflt(); in_rm = 4'b0100; in_base = 4'b1101; in_index = 4'd2; in_scale = 2'b10; in_disp = 32'h1000;
      fire("R8 no base ext", (rfv(4'd2) << 2) + 64'h1000);
      dflt(); in_rm = 4'b0100; in_mod = 2'b01; in_base = 4'b0101; in_index = 4'd2;
      in_scale = 2'b10; in_disp = 32'h3;
      fire("R8 base 5 with disp8", rfv(4'd5) + (rfv(4'd2) << 2) + 64'h3);
      dflt(); in_rm = 4'b1100; in_base = 4'd3; in_index = 4'b0100;
      fire("R8 ext rm still scale-index", rfv(4'd3));
   endtask

   task automatic t_a32();
      dflt(); in_asz = 2'b01; in_long = 1'b0; in_rm = 4'd1; in_mod = 2'b10; in_disp = 32'h10;
      fire("R9 cut 32", lo32(rfv(4'd1) + 64'h10));
      dflt(); in_asz = 2'b01; in_long = 1'b0; in_rm = 4'b0100; in_mod = 2'b10;
      in_base = 4'd15; in_index = 4'd14; in_scale = 2'b11; in_disp = 32'hFFFF_0000;
      fire("R9 wrap 32", 64'h0086_707F);
   endtask

   task automatic t_pipe();
      dflt(); in_rm = 4'd1; in_mod = 2'b10; in_disp = 32'h100;
      @(negedge clk); in_valid = 1'b1;
      @(negedge clk); expect_idle("R10 first edge");
      in_mod = 2'b11;
      @(negedge clk); expect_addr("R10 back to back A", rfv(4'd1) + 64'h100);
      in_rm = 4'd2; in_mod = 2'b01; in_disp = 32'h4;
      @(negedge clk); expect_idle("R10 register operand");
      in_valid = 1'b0;
      @(negedge clk); expect_addr("R10 back to back C", rfv(4'd2) + 64'h4);
      @(negedge clk); expect_idle("R10 drained");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      finish_run();
   end

   initial begin
      dflt();
      repeat (3) @(negedge clk);
      t_reset();
      t_scale();
      t_disp64();
      t_a16();
      t_iprel();
      t_cdisp();
      t_noscale();
      t_index();
      t_nobase();
      t_a32();
      t_pipe();
      finish_run();
   end

endmodule